// File: doc/BRIEF.md
# Per-Hart Direct Interrupt Delivery Unit

This block is the wired delivery stage of an interrupt controller. For each hart it picks the best pending interrupt among the sources routed to that hart. It then drives one interrupt line per hart. The source-side logic lives in a neighbouring block. That neighbour supplies, per source:

- a combined enabled-and-pending flag;
- a flag saying whether the source is level-sensitive;
- the source input, already rectified so that 1 means "asserted".

In return, this block sends single-cycle pending-clear and pending-set strobes back to the neighbour when software claims an interrupt. The neighbour applies a set that arrives in the same cycle as a clear after the clear, so the set wins.

Software reaches the block through a simple word-wide register port. Each source `s` (1..NSRC) has a routing word at byte address `4*s`. It carries the hart number at bits 31:18 and the priority in the low `PRIO_W` bits. Each hart `h` has a 32-byte control window at `HART_BASE + 32*h`. The window holds the delivery enable, the force bit, the threshold, a top-interrupt word and a claim word. A lower priority number is more urgent.

Outputs are registered. A hart line, a read result or a strobe appears on the clock edge after the inputs or the access that cause it. Between two claims on one hart, at least two idle cycles must pass, so that the pending feedback has settled.

Top module: `ddlv_direct_deliver`

## Requirements
- R1: The routing word of source s sits at byte address 4*s. It stores the hart number from bits 31:18 and the priority from the low PRIO_W bits, and reads back in that layout with all other bits 0. A priority that is 0 after masking is stored as 1. After reset every routing word reads 1 (hart 0, priority 1).
- R2: A source is a candidate for hart h when its enabled-and-pending flag is 1 and its routing hart number equals h. Among the candidates, the lowest priority value wins, and on equal priority the lowest source number wins. Source 0 is never a candidate.
- R3: A nonzero threshold on a hart removes every candidate whose priority is greater than or equal to the threshold. A threshold of 0 removes nothing.
- R4: The top word at window offset 0x18 reads the winning source number at bits 25:16 and its priority at bits 7:0. It reads 0 when no candidate remains.
- R5: The line hart_irq[h] is 1 one cycle after these conditions hold: the domain enable is 1, the hart's delivery bit is 1, and either its force bit is 1 or a candidate remains. Otherwise the line is 0.
- R6: A read of the claim word at window offset 0x1C returns the top word. On the next cycle it pulses pend_clr for the winning source only. Strobe bit 0 never pulses.
- R7: If the claimed source is level-sensitive and its rectified input is 1, pend_set pulses for that source together with pend_clr, so that it stays pending. Otherwise pend_set stays 0.
- R8: A claim read with no candidate returns 0, pulses no strobe and clears that hart's force bit.
- R9: The delivery bit (offset 0x00) and force bit (offset 0x04) keep only bit 0 of a write. The threshold (offset 0x08) keeps the low PRIO_W bits. Writes to the top and claim words change nothing. A read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dom_ie | input | 1 | Domain interrupt enable |
| src_enpend | input | NSRC+1 | Per-source enabled-and-pending flag (bit 0 ignored) |
| src_level | input | NSRC+1 | 1 marks a level-sensitive source (bit 0 ignored) |
| src_rect_in | input | NSRC+1 | Rectified source input, 1 = asserted (bit 0 ignored) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en, held until the next read |
| hart_irq | output | NHART | Interrupt line per hart |
| pend_clr | output | NSRC+1 | One-cycle pending-clear strobe per source |
| pend_set | output | NSRC+1 | One-cycle pending-set strobe per source |

## Verification
The bench builds the block with 12 sources, 2 harts and a 3-bit priority.

- With only eight priority values, random routing produces equal-priority ties and threshold cut-offs often.
- Two harts let routing to the other hart, and to a nonexistent hart number, be exercised.
- The narrow priority field brings the mask-to-zero-then-store-1 case and threshold masking within reach of directed writes.
- Claims run against randomly mixed level and edge sources, with random inputs, to exercise both the re-arm path and the plain-clear path.

// File: rtl/ddlv_pkg.sv
// Package: shared constants and the selection result type of the direct
// delivery unit. Assumes priorities never exceed 8 bits and source numbers
// never exceed 10 bits.
package ddlv_pkg;
    localparam int TGT_HART_LSB = 18;
    localparam int TGT_HART_W   = 14;

    localparam logic [4:0] OFS_DELIV  = 5'h00;
    localparam logic [4:0] OFS_FORCE  = 5'h04;
    localparam logic [4:0] OFS_THRESH = 5'h08;
    localparam logic [4:0] OFS_TOP    = 5'h18;
    localparam logic [4:0] OFS_CLAIM  = 5'h1C;

    typedef struct packed {
        logic       valid;
        logic [9:0] id;
        logic [7:0] prio;
    } top_t;

    // Software view of a selection result.
    function automatic logic [31:0] top_word(top_t t);
        return t.valid ? {6'b0, t.id, 8'b0, t.prio} : 32'h0;
    endfunction
endpackage

// File: rtl/ddlv_target_regs.sv
// Module: routing words, one per source (hart number plus priority).
// Assumes addresses 4*s, s = 1..NSRC, are reserved for these words.
// A priority that masks to zero is stored as one.
module ddlv_target_regs #(
    parameter int NSRC   = 63,
    parameter int PRIO_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         wr_en,
    input  logic [ADDR_W-1:0]                            addr,
    input  logic [31:0]                                  wdata,
    output logic [NSRC:0][ddlv_pkg::TGT_HART_W-1:0]      tgt_hart,
    output logic [NSRC:0][PRIO_W-1:0]                    tgt_prio
);
    import ddlv_pkg::*;

    localparam int SRC_W = $clog2(NSRC + 1);

    logic              sel;
    logic [SRC_W-1:0]  idx;
    logic [PRIO_W-1:0] wprio;

    // Decode a write that lands on a routing word.
    always_comb begin
        idx   = addr[SRC_W+1:2];
        sel   = wr_en && (addr[1:0] == 2'b00) && (addr[ADDR_W-1:2] != '0)
                && (addr[ADDR_W-1:2] <= (ADDR_W-2)'(NSRC));
        wprio = (wdata[PRIO_W-1:0] == '0) ? PRIO_W'(1) : wdata[PRIO_W-1:0];
    end

    // Hold the routing words; reset value is hart 0, priority 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s <= NSRC; s++) begin
                tgt_hart[s] <= '0;
                tgt_prio[s] <= PRIO_W'(1);
            end
        end else if (sel) begin
            tgt_hart[idx] <= wdata[TGT_HART_LSB +: TGT_HART_W];
            tgt_prio[idx] <= wprio;
        end
    end
endmodule

// File: rtl/ddlv_hart_ctrl.sv
// Module: per-hart control bits (delivery enable, force, threshold).
// Assumes the caller decodes the window offsets. A direct write to force
// takes precedence over the clear caused by an empty claim.
module ddlv_hart_ctrl #(
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_deliv,
    input  logic              wr_force,
    input  logic              wr_thresh,
    input  logic              claim_none,
    input  logic [31:0]       wdata,
    output logic              deliv,
    output logic              frc,
    output logic [PRIO_W-1:0] thresh
);
    // Update the three control registers of one hart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deliv  <= 1'b0;
            frc    <= 1'b0;
            thresh <= '0;
        end else begin
            if (wr_deliv)        deliv  <= wdata[0];
            if (wr_force)        frc    <= wdata[0];
            else if (claim_none) frc    <= 1'b0;
            if (wr_thresh)       thresh <= wdata[PRIO_W-1:0];
        end
    end
endmodule

// File: rtl/ddlv_select.sv
// Module: combinational best-interrupt scan for one hart.
// Scans sources in ascending order with a strict compare, so that on equal
// priority the lower source number is kept. Source 0 is skipped.
module ddlv_select #(
    parameter int NSRC   = 63,
    parameter int PRIO_W = 8,
    parameter int HART   = 0
) (
    input  logic [NSRC:0]                             enpend,
    input  logic [NSRC:0][ddlv_pkg::TGT_HART_W-1:0]   tgt_hart,
    input  logic [NSRC:0][PRIO_W-1:0]                 tgt_prio,
    input  logic [PRIO_W-1:0]                         thresh,
    output ddlv_pkg::top_t                            top
);
    import ddlv_pkg::*;

    // Pick the lowest priority value under the threshold.
    always_comb begin
        top = '0;
        for (int s = 1; s <= NSRC; s++) begin
            if (enpend[s] && (tgt_hart[s] == TGT_HART_W'(HART))
                && ((thresh == '0) || (tgt_prio[s] < thresh))
                && (!top.valid || (8'(tgt_prio[s]) < top.prio))) begin
                top.valid = 1'b1;
                top.id    = 10'(s);
                top.prio  = 8'(tgt_prio[s]);
            end
        end
    end
endmodule

// File: rtl/ddlv_direct_deliver.sv
// Module: top of the per-hart direct delivery unit. It decodes the register
// port, selects per hart, registers the hart lines, the read data and the
// claim strobes.
// Assumes that rd_en and wr_en never hit the same hart window in one cycle,
// that HART_BASE is 32-byte aligned and above the routing words, and that
// claims on a hart are spaced at least two idle cycles apart.
module ddlv_direct_deliver #(
    parameter int NSRC      = 63,
    parameter int NHART     = 4,
    parameter int PRIO_W    = 8,
    parameter int ADDR_W    = 16,
    parameter int HART_BASE = 16'h0400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dom_ie,
    input  logic [NSRC:0]     src_enpend,
    input  logic [NSRC:0]     src_level,
    input  logic [NSRC:0]     src_rect_in,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NHART-1:0]  hart_irq,
    output logic [NSRC:0]     pend_clr,
    output logic [NSRC:0]     pend_set
);
    import ddlv_pkg::*;

    localparam int SRC_W = $clog2(NSRC + 1);
    localparam int HW    = (NHART > 1) ? $clog2(NHART) : 1;
    localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(HART_BASE);
    localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(HART_BASE + 32 * NHART);

    logic [NSRC:0][TGT_HART_W-1:0] tgt_hart;
    logic [NSRC:0][PRIO_W-1:0]     tgt_prio;
    logic [NHART-1:0]              deliv, frc;
    logic [PRIO_W-1:0]             thresh [NHART];
    top_t                          top    [NHART];

    logic              in_win, in_tgt, claim_rd;
    logic [ADDR_W-1:0] win_off;
    logic [HW-1:0]     hsel;
    logic [4:0]        ofs;
    logic [SRC_W-1:0]  tidx, cid;
    top_t              top_sel;
    logic [31:0]       rd_word;

    ddlv_target_regs #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_tgt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .tgt_hart(tgt_hart), .tgt_prio(tgt_prio)
    );

    // Address decode for hart windows and routing words.
    always_comb begin
        in_win   = (addr >= WIN_LO) && (addr < WIN_HI);
        win_off  = addr - WIN_LO;
        hsel     = win_off[HW+4:5];
        ofs      = addr[4:0];
        in_tgt   = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:2] != '0)
                   && (addr[ADDR_W-1:2] <= (ADDR_W-2)'(NSRC));
        tidx     = addr[SRC_W+1:2];
        claim_rd = rd_en && in_win && (ofs == OFS_CLAIM);
    end

    for (genvar h = 0; h < NHART; h++) begin : g_hart
        logic hit;
        assign hit = in_win && (hsel == HW'(h));

        ddlv_hart_ctrl #(.PRIO_W(PRIO_W)) u_ctrl (
            .clk(clk), .rst_n(rst_n),
            .wr_deliv (wr_en && hit && (ofs == OFS_DELIV)),
            .wr_force (wr_en && hit && (ofs == OFS_FORCE)),
            .wr_thresh(wr_en && hit && (ofs == OFS_THRESH)),
            .claim_none(rd_en && hit && (ofs == OFS_CLAIM) && !top[h].valid),
            .wdata(wdata), .deliv(deliv[h]), .frc(frc[h]), .thresh(thresh[h])
        );

        ddlv_select #(.NSRC(NSRC), .PRIO_W(PRIO_W), .HART(h)) u_sel (
            .enpend(src_enpend), .tgt_hart(tgt_hart), .tgt_prio(tgt_prio),
            .thresh(thresh[h]), .top(top[h])
        );
    end

    // Read mux for routing words and window registers.
    always_comb begin
        top_sel = top[hsel];
        cid     = top_sel.id[SRC_W-1:0];
        rd_word = 32'h0;
        if (in_tgt) begin
            rd_word = {tgt_hart[tidx], 18'(tgt_prio[tidx])};
        end else if (in_win) begin
            case (ofs)
                OFS_DELIV:           rd_word = {31'b0, deliv[hsel]};
                OFS_FORCE:           rd_word = {31'b0, frc[hsel]};
                OFS_THRESH:          rd_word = 32'(thresh[hsel]);
                OFS_TOP, OFS_CLAIM:  rd_word = top_word(top_sel);
                default:             rd_word = 32'h0;
            endcase
        end
    end

    // Register read data, claim strobes and hart lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= 32'h0;
            pend_clr <= '0;
            pend_set <= '0;
            hart_irq <= '0;
        end else begin
            pend_clr <= '0;
            pend_set <= '0;
            if (rd_en) rdata <= rd_word;
            if (claim_rd && top_sel.valid) begin
                pend_clr[cid] <= 1'b1;
                if (src_level[cid] && src_rect_in[cid]) pend_set[cid] <= 1'b1;
            end
            for (int h = 0; h < NHART; h++)
                hart_irq[h] <= dom_ie && deliv[h] && (frc[h] || top[h].valid);
        end
    end
endmodule

// File: rtl/ddlv_checker.sv
// Module: protocol checks on the ports of the direct delivery unit,
// attached to every instance of the top by the bind below.
module ddlv_checker #(
    parameter int NSRC  = 63,
    parameter int NHART = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dom_ie,
    input logic             rd_en,
    input logic [NHART-1:0] hart_irq,
    input logic [NSRC:0]    pend_clr,
    input logic [NSRC:0]    pend_set
);
    // R5: no hart line the cycle after the domain enable is off
    a_r5_domain_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !dom_ie |=> (hart_irq == '0));

    // R6: at most one source is cleared per claim
    a_r6_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_clr));

    // R6: a clear strobe only follows a read access
    a_r6_clr_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr != '0) |-> $past(rd_en));

    // R6: source 0 is never strobed
    a_r6_src0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_clr[0] && !pend_set[0]);

    // R7: a re-arm strobe only comes paired with the clear of the same source
    a_r7_set_with_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_set & ~pend_clr) == '0);
endmodule

bind ddlv_direct_deliver ddlv_checker #(.NSRC(NSRC), .NHART(NHART)) u_chk (
    .clk(clk), .rst_n(rst_n), .dom_ie(dom_ie), .rd_en(rd_en),
    .hart_irq(hart_irq), .pend_clr(pend_clr), .pend_set(pend_set)
);

// File: tb/tb_ddlv_direct_deliver.sv
module tb_ddlv_direct_deliver;
    localparam int NSRC = 12, NHART = 2, PRIO_W = 3, ADDR_W = 16;
    localparam int HB = 16'h0400;

    logic clk = 1'b0, rst_n = 1'b0, dom_ie = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic [NHART-1:0] hart_irq;
    logic [NSRC:0] pend_clr, pend_set;
    logic [NSRC:0] pend = '0, en = '0, lvl = '0, rin = '0;
    logic [NSRC:0] src_enpend;

    int tests = 0, fails = 0;
    int m_hart [NSRC+1];
    int m_prio [NSRC+1];
    int m_thr [NHART], m_del [NHART], m_frc [NHART];

    always #2 clk = ~clk;
    assign src_enpend = pend & en;

    // neighbour source logic: applies the strobes, set after clear
    always @(posedge clk) if (rst_n) pend <= (pend & ~pend_clr) | pend_set;

    ddlv_direct_deliver #(.NSRC(NSRC), .NHART(NHART), .PRIO_W(PRIO_W),
        .ADDR_W(ADDR_W), .HART_BASE(HB)) dut (
        .clk(clk), .rst_n(rst_n), .dom_ie(dom_ie), .src_enpend(src_enpend),
        .src_level(lvl), .src_rect_in(rin), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .hart_irq(hart_irq),
        .pend_clr(pend_clr), .pend_set(pend_set));

    function automatic logic [15:0] win(int h, int o);
        return 16'(HB + 32 * h + o);
    endfunction

    function automatic logic [31:0] exp_top(int h);
        int best = -1, bp = 0;
        for (int s = 1; s <= NSRC; s++)
            if (pend[s] && en[s] && m_hart[s] == h &&
                (m_thr[h] == 0 || m_prio[s] < m_thr[h]) &&
                (best < 0 || m_prio[s] < bp)) begin
                best = s; bp = m_prio[s];
            end
        return (best < 0) ? 32'h0 : 32'((best << 16) | bp);
    endfunction

    function automatic logic exp_irq(int h);
        return dom_ie && m_del[h] != 0 && (m_frc[h] != 0 || exp_top(h) != 0);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic set_tgt(input int s, input int h, input int p);
        wr(16'(4 * s), (32'(h) << 18) | 32'(p));
        m_hart[s] = h;
        m_prio[s] = ((p & 7) == 0) ? 1 : (p & 7);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // claim on hart h, check return, strobes and resulting pending state
    task automatic claim(input int h, input string tag);
        logic [31:0] e, d;
        logic [NSRC:0] ep, ec, es;
        int id;
        e = exp_top(h); id = int'(e[25:16]);
        ep = pend; ec = '0; es = '0;
        if (e != 0) begin
            ec[id] = 1'b1; ep[id] = 1'b0;
            if (lvl[id] && rin[id]) begin es[id] = 1'b1; ep[id] = 1'b1; end
        end else m_frc[h] = 0;
        rd(win(h, 'h1C), d);
        chk({tag, " R6 claim value"}, d, e);
        chk({tag, " R6 clear strobe"}, 32'(pend_clr), 32'(ec));
        chk({tag, " R7 set strobe"}, 32'(pend_set), 32'(es));
        idle(2);
        chk({tag, " R7 pending after claim"}, 32'(pend), 32'(ep));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", tests, -1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20250611));
        for (int s = 0; s <= NSRC; s++) begin m_hart[s] = 0; m_prio[s] = 1; end
        for (int h = 0; h < NHART; h++) begin m_thr[h] = 0; m_del[h] = 0; m_frc[h] = 0; end
        idle(4); rst_n = 1'b1; idle(1);

        // reset state
        chk("R5 reset lines", 32'(hart_irq), 32'h0);
        rd(16'(4 * 1), d);      chk("R1 reset target", d, 32'h1);
        rd(16'(4 * NSRC), d);   chk("R1 reset last target", d, 32'h1);
        rd(win(0, 'h18), d);    chk("R4 reset top", d, 32'h0);

        // R1 routing word layout and priority masking
        set_tgt(3, 1, 0);  rd(16'(12), d); chk("R1 zero prio -> 1", d, (32'd1 << 18) | 1);
        set_tgt(3, 1, 'h1F); rd(16'(12), d); chk("R1 prio masked", d, (32'd1 << 18) | 7);
        set_tgt(3, 1, 8);  rd(16'(12), d); chk("R1 masked zero -> 1", d, (32'd1 << 18) | 1);
        rd(16'h0000, d); chk("R9 unmapped read", d, 32'h0);

        // R9 window registers
        wr(win(0, 0), 32'hFFFF_FFFF); m_del[0] = 1;
        rd(win(0, 0), d); chk("R9 delivery keeps bit0", d, 32'h1);
        wr(win(0, 8), 32'hFF); rd(win(0, 8), d); chk("R9 threshold masked", d, 32'h7);
        wr(win(0, 8), 32'h0); rd(win(0, 4), d); chk("R9 force reset", d, 32'h0);

        // R2 tie: sources 2 and 5 equal priority on hart 0
        set_tgt(2, 0, 2); set_tgt(5, 0, 2); set_tgt(7, 0, 4);
        en = '1; en[0] = 1'b0;
        @(negedge clk); pend = 14'b0; pend[2] = 1; pend[5] = 1; pend[7] = 1;
        idle(1); rd(win(0, 'h18), d); chk("R2 tie lower number", d, exp_top(0));
        chk("R2 tie expected id2", d, (32'd2 << 16) | 2);
        wr(win(0, 'h18), 32'h0); wr(win(0, 'h1C), 32'h0);
        rd(win(0, 'h18), d); chk("R9 top write ignored", d, (32'd2 << 16) | 2);
        // R3 threshold 2 keeps nothing of priority >= 2
        wr(win(0, 8), 32'h2); m_thr[0] = 2;
        rd(win(0, 'h18), d); chk("R3 threshold excludes", d, 32'h0);
        wr(win(0, 8), 32'h5); m_thr[0] = 5;
        rd(win(0, 'h18), d); chk("R3 threshold passes", d, (32'd2 << 16) | 2);
        // R5 line gating
        dom_ie = 1'b1; idle(2); chk("R5 line on", 32'(hart_irq), 32'b01);
        dom_ie = 1'b0; idle(2); chk("R5 domain off", 32'(hart_irq), 32'b00);
        dom_ie = 1'b1;
        // R7 level source re-armed, then edge source cleared
        lvl[2] = 1; rin[2] = 1; claim(0, "dir level");
        rin[2] = 0; claim(0, "dir level low");
        lvl[5] = 0; claim(0, "dir edge");
        // R8 empty claim clears force
        @(negedge clk); pend = '0;
        wr(win(0, 4), 32'h3); m_frc[0] = 1;
        idle(2); chk("R8 force drives line", 32'(hart_irq), 32'b01);
        claim(0, "R8 empty");
        rd(win(0, 4), d); chk("R8 force cleared", d, 32'h0);
        idle(1); chk("R8 line drops", 32'(hart_irq), 32'b00);

        // random phase
        for (int it = 0; it < 300; it++) begin
            int h, s;
            if ($urandom_range(3) == 0) begin
                s = int'($urandom_range(NSRC, 1));
                set_tgt(s, int'($urandom_range(NHART)), int'($urandom_range(7)));
            end
            if ($urandom_range(5) == 0) begin
                h = int'($urandom_range(NHART - 1));
                m_thr[h] = int'($urandom_range(7));
                wr(win(h, 8), 32'(m_thr[h]));
            end
            if ($urandom_range(5) == 0) begin
                h = int'($urandom_range(NHART - 1));
                m_del[h] = int'($urandom_range(1)); wr(win(h, 0), 32'(m_del[h]));
                m_frc[h] = int'($urandom_range(1)); wr(win(h, 4), 32'(m_frc[h]));
            end
            @(negedge clk);
            pend = NSRC'($urandom) << 1; en = NSRC'($urandom) << 1;
            lvl = NSRC'($urandom) << 1; rin = NSRC'($urandom) << 1;
            dom_ie = ($urandom_range(7) != 0);
            idle(2);
            for (int k = 0; k < NHART; k++) begin
                rd(win(k, 'h18), d); chk("R2 R3 R4 random top", d, exp_top(k));
            end
            for (int k = 0; k < NHART; k++)
                chk("R5 random line", 32'(hart_irq[k]), 32'(exp_irq(k)));
            s = int'($urandom_range(NSRC, 1));
            rd(16'(4 * s), d);
            chk("R1 random readback", d, (32'(m_hart[s]) << 18) | 32'(m_prio[s]));
            claim(int'($urandom_range(NHART - 1)), "random");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule